// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Interface

This block is the bus-facing front end of an 8192-byte serial memory. It watches oversampled clock and data lines for bus START and STOP conditions, shifts bytes in and out most significant bit first, and pulls the open-drain data line low to acknowledge. A device byte selects the part: its upper nibble must hold the fixed control code, and its next three bits must match the three strap inputs. The last bit of the device byte chooses the direction. With these straps, eight such memories can share one bus.

A write transfer carries two word-address bytes followed by data bytes. Each data byte is handed to a page buffer through a one-cycle strobe, and the address advances inside its 32-byte page. A STOP after written data raises a commit pulse so the programming engine can start. A read transfer returns bytes from a combinational memory read port. The address pointer advances through the whole array and wraps from the top back to zero. The master ends a read by withholding its acknowledge and then sending a STOP. The array, the programming timer and the analog input filters sit outside this block.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the data line is released (`sdaDriveLow` = 0), and `wrValid` and `wrCommit` are 0.
- R2: A START (data falling while clock is high) in any state begins a new device-byte phase with the bit count cleared. This includes a START in the middle of a byte or transfer.
- R3: The device byte is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap[2:0]`. The acknowledge holds `sdaDriveLow` = 1 through the ninth clock. A byte that does not match gets no acknowledge, and neither does any later byte until the next START.
- R4: Received bits are sampled on rising clock edges, most significant bit first, eight per byte.
- R5: After a device byte with bit 0 = 0, two address bytes are acknowledged. Bits 7:5 of the first address byte are ignored, and the word address becomes {first[4:0], second[7:0]}.
- R6: Each later byte is acknowledged and appears for exactly one cycle on `wrValid` with `wrAddr` and `wrData`. The address then advances with its low five bits wrapping inside the 32-byte page.
- R7: A STOP that follows at least one data byte, with no START in between, gives a one-cycle `wrCommit`. A STOP after a read, or after an address-only write, gives none. A START discards pending data.
- R8: After a device byte with bit 0 = 1, the slave sends the byte at `memRdAddr` most significant bit first, changing bits after clock falling edges. The pointer advances by one after each byte is loaded and wraps from 8191 to 0.
- R9: A master acknowledge (low in the ninth clock) continues the read. A missing acknowledge makes the slave release the line and stay silent until the next START.
- R10: A read with no address phase starts from the pointer left by the previous access.
- R11: A STOP (data rising while clock is high) releases the data line and returns the slave to standby.
- R12: `sdaDriveLow` changes only after a clock falling edge, a START or a STOP. It never changes while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line sample |
| sdaIn | input | 1 | Serial data line sample (wired bus level) |
| sdaDriveLow | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | 3 | Device select straps |
| memRdAddr | output | 13 | Read address to the array |
| memRdData | input | 8 | Combinational read data for `memRdAddr` |
| wrValid | output | 1 | One-cycle strobe for a received write byte |
| wrAddr | output | 13 | Array address of the write byte |
| wrData | output | 8 | Write byte value |
| wrCommit | output | 1 | One-cycle pulse: start programming the page |

## Verification
A bit counter that is off by one moves the acknowledge into the wrong clock. The first device byte then reads as not acknowledged, or data bits come out shifted, within nine clocks. A pointer that is wrong or fails to wrap shows in the first returned byte past the error, because each read byte is compared against an arithmetic function of its address. A bad page increment or a lost address bit shows in the first `wrAddr` after the fault. A commit flag that is wrongly kept or dropped shows at the very next STOP.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVSEL,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_WRITE,
    PH_READ
  } phase_t;

  // strobes from control to datapath, at most one address action per cycle
  typedef struct packed {
    logic shiftIn;
    logic captureHi;
    logic captureLo;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_mem_datapath.sv
module i2c_mem_datapath
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] addrPtr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam int HI_W = ADDR_W - 8;

  logic [7:0]        rxReg;
  logic [7:0]        txReg;
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [7:0]        wrDataQ;
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] linearNext;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flatPage
      assign pageNext = addrReg + ADDR_W'(1);
    end else begin : g_splitPage
      logic [PAGE_W-1:0] offsetNext;
      assign offsetNext = addrReg[PAGE_W-1:0] + PAGE_W'(1);
      assign pageNext   = {addrReg[ADDR_W-1:PAGE_W], offsetNext};
    end
  endgenerate

  assign linearNext = addrReg + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '1;
      hiReg   <= '0;
      addrReg <= '0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      if (strobe.shiftIn)   rxReg <= {rxReg[6:0], sdaBit};
      if (strobe.captureHi) hiReg <= rxReg[HI_W-1:0];
      if (strobe.captureLo) begin
        addrReg <= {hiReg, rxReg};
      end else if (strobe.writeByte) begin
        wrAddrQ <= addrReg;
        wrDataQ <= rxReg;
        addrReg <= pageNext;
      end else if (strobe.loadTx) begin
        txReg   <= memRdData;
        addrReg <= linearNext;
      end
      if (strobe.shiftTx) txReg <= {txReg[6:0], 1'b1};
    end
  end

  assign rxByte  = rxReg;
  assign txBit   = txReg[7];
  assign addrPtr = addrReg;
  assign wrAddr  = wrAddrQ;
  assign wrData  = wrDataQ;

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] CTRL_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaSample,
  output logic       sdaDriveLow,
  output logic       wrValid,
  output logic       wrCommit,
  output logic       startDet,
  output logic       stopDet,
  output logic       fallDet,
  output logic       ackLow,
  output logic [3:0] bitCnt
);

  logic   sclQ, sdaQ, sclP, sdaP;
  logic   riseDet;
  logic   slotOpen, byteDone, rxPhase, devMatch;
  phase_t phase;
  logic   txActive, readMode, hostAck, wroteAny;
  logic   wrValidQ, wrCommitQ, ackLowQ;
  logic [3:0] bitCntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      sclP <= sclQ;
      sdaP <= sdaQ;
    end
  end

  assign riseDet  = sclQ & ~sclP;
  assign fallDet  = ~sclQ & sclP;
  assign startDet = sclQ & sclP & sdaP & ~sdaQ;
  assign stopDet  = sclQ & sclP & ~sdaP & sdaQ;

  assign rxPhase  = (phase == PH_DEVSEL) || (phase == PH_ADDR_HI) ||
                    (phase == PH_ADDR_LO) || (phase == PH_WRITE);
  assign slotOpen = fallDet && (bitCntQ == 4'd8);
  assign byteDone = fallDet && (bitCntQ == 4'd9);
  assign devMatch = (rxByte[7:4] == CTRL_CODE) && (rxByte[3:1] == strap);

  always_comb begin
    strobe           = '0;
    strobe.shiftIn   = riseDet && rxPhase && (bitCntQ < 4'd8);
    strobe.captureHi = slotOpen && (phase == PH_ADDR_HI);
    strobe.captureLo = slotOpen && (phase == PH_ADDR_LO);
    strobe.writeByte = slotOpen && (phase == PH_WRITE);
    strobe.loadTx    = byteDone && (((phase == PH_DEVSEL) && readMode) ||
                                    ((phase == PH_READ) && hostAck));
    strobe.shiftTx   = fallDet && (phase == PH_READ) &&
                       (bitCntQ >= 4'd1) && (bitCntQ <= 4'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCntQ   <= '0;
      ackLowQ   <= 1'b0;
      txActive  <= 1'b0;
      readMode  <= 1'b0;
      hostAck   <= 1'b0;
      wroteAny  <= 1'b0;
      wrValidQ  <= 1'b0;
      wrCommitQ <= 1'b0;
    end else begin
      wrValidQ  <= strobe.writeByte;
      wrCommitQ <= 1'b0;
      if (startDet) begin
        phase    <= PH_DEVSEL;
        bitCntQ  <= '0;
        ackLowQ  <= 1'b0;
        txActive <= 1'b0;
        wroteAny <= 1'b0;
      end else if (stopDet) begin
        phase     <= PH_IDLE;
        bitCntQ   <= '0;
        ackLowQ   <= 1'b0;
        txActive  <= 1'b0;
        wrCommitQ <= wroteAny;
        wroteAny  <= 1'b0;
      end else begin
        if (riseDet && (phase != PH_IDLE) && (bitCntQ < 4'd9))
          bitCntQ <= bitCntQ + 4'd1;
        if (riseDet && (phase == PH_READ) && (bitCntQ == 4'd8))
          hostAck <= ~sdaQ;
        if (strobe.writeByte) wroteAny <= 1'b1;
        if (slotOpen) begin
          case (phase)
            PH_DEVSEL: begin
              if (devMatch) begin
                ackLowQ  <= 1'b1;
                readMode <= rxByte[0];
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_ADDR_HI, PH_ADDR_LO, PH_WRITE: ackLowQ <= 1'b1;
            PH_READ:   txActive <= 1'b0;
            default:   ;
          endcase
        end
        if (byteDone) begin
          bitCntQ <= '0;
          ackLowQ <= 1'b0;
          case (phase)
            PH_DEVSEL: begin
              phase    <= readMode ? PH_READ : PH_ADDR_HI;
              txActive <= readMode;
            end
            PH_ADDR_HI: phase <= PH_ADDR_LO;
            PH_ADDR_LO: phase <= PH_WRITE;
            PH_READ: begin
              if (hostAck) begin
                txActive <= 1'b1;
              end else begin
                phase    <= PH_IDLE;
                txActive <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sdaSample   = sdaQ;
  assign ackLow      = ackLowQ;
  assign bitCnt      = bitCntQ;
  assign sdaDriveLow = ackLowQ | (txActive & ~txBit);
  assign wrValid     = wrValidQ;
  assign wrCommit    = wrCommitQ;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W    = 13,
  parameter int         PAGE_W    = 5,
  parameter logic [3:0] CTRL_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [2:0]        strap,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);

  dpStrobe_t  strobe;
  logic       sdaSample;
  logic [7:0] rxByte;
  logic       txBit;
  logic       startDet, stopDet, fallDet, ackLow;
  logic [3:0] bitCnt;

  i2c_mem_ctrl #(.CTRL_CODE(CTRL_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe), .sdaSample(sdaSample),
    .sdaDriveLow(sdaDriveLow), .wrValid(wrValid), .wrCommit(wrCommit),
    .startDet(startDet), .stopDet(stopDet), .fallDet(fallDet),
    .ackLow(ackLow), .bitCnt(bitCnt)
  );

  i2c_mem_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaSample),
    .memRdData(memRdData), .rxByte(rxByte), .txBit(txBit),
    .addrPtr(memRdAddr), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaDriveLow,
  input logic       wrValid,
  input logic       wrCommit,
  input logic       startDet,
  input logic       stopDet,
  input logic       fallDet,
  input logic       ackLow,
  input logic [3:0] bitCnt
);

  assert_ack_in_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackLow |-> (bitCnt >= 4'd8));

  assert_write_acked_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ackLow);

  assert_write_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

  assert_drive_on_fall_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> $past(fallDet || startDet || stopDet));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .wrValid(wrValid),
  .wrCommit(wrCommit), .startDet(startDet), .stopDet(stopDet),
  .fallDet(fallDet), .ackLow(ackLow), .bitCnt(bitCnt)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;

  localparam int QTR = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic [2:0]  strapIn = 3'b000;
  logic        sdaDriveLow;
  logic [12:0] memRdAddr;
  logic [7:0]  memRdData;
  logic        wrValid, wrCommit;
  logic [12:0] wrAddr;
  logic [7:0]  wrData;
  wire         sdaBus = sdaM & ~sdaDriveLow;

  int checkCnt = 0;
  int passCnt = 0;
  int logN = 0;
  int commitCnt = 0;
  int unstableCnt = 0;
  logic [12:0] logAddr [32];
  logic [7:0]  logData [32];

  always #4 clk = ~clk;

  function automatic logic [7:0] byteOf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign memRdData = byteOf(memRdAddr);

  i2c_mem_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .strap(strapIn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit)
  );

  always @(negedge clk) begin
    if (wrValid && logN < 32) begin
      logAddr[logN] = wrAddr;
      logData[logN] = wrData;
      logN++;
    end
    if (wrCommit) commitCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = sdaDriveLow;
    sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    logic first;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclM = 1'b1; waitQ();
      first = sdaBus; waitQ();
      if (sdaBus != first) unstableCnt++;
      b[i] = first;
      sclM = 1'b0;
    end
    waitQ();
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    busStart();
    sendByte({4'b1010, strapIn, 1'b0}, a);
    check(a, "R3 devsel write ack", a, 1);
    sendByte(hi, a);
    check(a, "R5 addr hi ack", a, 1);
    sendByte(lo, a);
    check(a, "R5 addr lo ack", a, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rd;
    int base, cbase;
    logic [12:0] ea;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!sdaDriveLow, "R1 reset drive", sdaDriveLow, 0);
    check(!wrValid && !wrCommit, "R1 reset strobes", {wrValid, wrCommit}, 0);

    // R3: sweep straps against every select value, write direction
    for (int s = 0; s < 8; s++) begin
      strapIn = 3'(s);
      for (int sel = 0; sel < 8; sel++) begin
        busStart();
        sendByte({4'b1010, 3'(sel), 1'b0}, a);
        check(a == (sel == s), "R3 select match", a, (sel == s));
        busStop();
      end
    end
    check(commitCnt == 0, "R7 no commit address-less", commitCnt, 0);

    strapIn = 3'b101;
    // R3: wrong control code, then following bytes also ignored
    base = logN;
    busStart();
    sendByte({4'b1011, 3'b101, 1'b0}, a);
    check(!a, "R3 wrong code no ack", a, 0);
    sendByte(8'h00, a);
    check(!a, "R3 silent after mismatch", a, 0);
    sendByte(8'h55, a);
    check(!a && logN == base, "R3 no write after mismatch", logN - base, 0);
    // R2: repeated START after mismatch and mid-byte
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart();
    sendByte({4'b1010, 3'b101, 1'b0}, a);
    check(a, "R2 restart mid-byte ack", a, 1);
    busStop();
    check(!sdaDriveLow, "R11 released after stop", sdaDriveLow, 0);

    // R4 R5 R6 R7: write three bytes, high address bits 7:5 set
    base = logN; cbase = commitCnt;
    setAddr(8'hF2, 8'h34);
    sendByte(8'h5A, a); check(a, "R6 data ack", a, 1);
    sendByte(8'hC3, a); check(a, "R6 data ack", a, 1);
    sendByte(8'h0F, a); check(a, "R6 data ack", a, 1);
    busStop();
    repeat (4) @(negedge clk);
    check(logN - base == 3, "R6 write count", logN - base, 3);
    check(logAddr[base] == 13'h1234, "R5 address ignores high bits", logAddr[base], 13'h1234);
    check(logAddr[base+1] == 13'h1235, "R6 address step", logAddr[base+1], 13'h1235);
    check(logData[base] == 8'h5A, "R4 data order", logData[base], 8'h5A);
    check(logData[base+1] == 8'hC3, "R4 data order", logData[base+1], 8'hC3);
    check(logData[base+2] == 8'h0F, "R4 data order", logData[base+2], 8'h0F);
    check(commitCnt == cbase + 1, "R7 commit after write stop", commitCnt - cbase, 1);

    // R6: page roll-over inside a 32-byte page
    base = logN;
    setAddr(8'h1F, 8'h3E);
    for (int k = 0; k < 4; k++) sendByte(8'(8'h80 + k), a);
    busStop();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      ea = {8'h1F, 3'b001, 5'(5'd30 + 5'(k))};
      check(logAddr[base+k] == ea, "R6 page wrap address", logAddr[base+k], ea);
    end

    // R7: START discards pending write, address-only write gives no commit
    cbase = commitCnt; base = logN;
    setAddr(8'h01, 8'h00);
    sendByte(8'h77, a);
    busStart();
    busStop();
    repeat (4) @(negedge clk);
    check(commitCnt == cbase && logN == base + 1, "R7 start discards commit", commitCnt - cbase, 0);
    setAddr(8'h02, 8'h00);
    busStop();
    repeat (4) @(negedge clk);
    check(commitCnt == cbase, "R7 address-only no commit", commitCnt - cbase, 0);

    // R8 R9: random read with sequential bytes
    cbase = commitCnt; unstableCnt = 0;
    setAddr(8'h0A, 8'hB0);
    busStart();
    sendByte({4'b1010, 3'b101, 1'b1}, a);
    check(a, "R3 devsel read ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, rd);
      ea = 13'h0AB0 + 13'(k);
      check(rd == byteOf(ea), "R8 read data", rd, byteOf(ea));
    end
    busStop();
    repeat (4) @(negedge clk);
    check(commitCnt == cbase, "R7 no commit after read", commitCnt - cbase, 0);
    check(!sdaDriveLow, "R11 released after read stop", sdaDriveLow, 0);
    check(unstableCnt == 0, "R12 stable while clock high", unstableCnt, 0);

    // R8 wrap, R9 silence after missing acknowledge
    setAddr(8'h1F, 8'hFE);
    busStart();
    sendByte({4'b1010, 3'b101, 1'b1}, a);
    for (int k = 0; k < 4; k++) begin
      readByte(k != 3, rd);
      ea = 13'h1FFE + 13'(k);
      check(rd == byteOf(ea), "R8 wrap read data", rd, byteOf(ea));
    end
    readByte(1'b0, rd);
    check(rd == 8'hFF, "R9 silent after nack", rd, 8'hFF);
    busStop();

    // R10: current-address read continues from pointer 2
    busStart();
    sendByte({4'b1010, 3'b101, 1'b1}, a);
    check(a, "R10 devsel read ack", a, 1);
    readByte(1'b0, rd);
    check(rd == byteOf(13'h0002), "R10 current address read", rd, byteOf(13'h0002));
    busStop();
    check(unstableCnt == 0, "R12 stable while clock high", unstableCnt, 0);

    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

endmodule